// File: doc/BRIEF.md
# CAN Transmit Channel Scan Arbiter

This block decides which of a parameterised set of message channels may use the shared CAN transmitter next. While the bus is idle it walks through the channels one at a time, from index 0 up to the last index. During each pass it keeps the channel that is enabled, set to the transmit direction, and carries the smallest identifier. A smaller identifier means a higher bus priority. Once the pass is over, one closing cycle follows. If a candidate was found, the block then raises a single-cycle start request together with the winning channel index.

Each channel visit costs two clocks. A channel that is enabled and set to transmit costs one more clock for the identifier comparison. The length of a pass therefore depends on the channel states, and it never exceeds three clocks per channel plus one. The winning index is held until the transmitter acknowledges that it is done. Scanning stops while the bus is busy. A pass that the bus interrupts is discarded, and the next pass starts again from channel 0.

Top module: `can_tx_scan_arb`

## Requirements
- R1: Scanning runs only while `bus_idle` is 1. `scan_busy` is 1 in every cycle of a pass, and a pass visits channels in ascending index order starting at 0.
- R2: A channel with `ch_en`=1 and `ch_dir_tx`=1 (1 means transmit) takes 3 clocks to visit, and any other channel takes 2. One closing cycle ends the pass, so a pass lasts 2*NUM_CH + k + 1 clocks, where k is the number of enabled transmit channels. This is at most 49 clocks for 16 channels and at most 97 clocks for 32 channels.
- R3: The winner is the enabled transmit channel with the numerically lowest identifier. Disabled channels and receive channels are ignored, whatever their identifier.
- R4: When identifiers are equal, the lower channel index wins.
- R5: `tx_start` is 1 for exactly one clock, in the clock after the closing cycle, and `tx_ch` is valid in that clock.
- R6: If a pass finds no enabled transmit channel, no `tx_start` is issued and the next pass follows at once, so `scan_busy` stays 1 while `bus_idle` stays 1.
- R7: If `bus_idle` drops during a pass, `scan_busy` is 0 from the next clock on. The pass and its candidate are discarded, and no `tx_start` is issued. The next pass starts at channel 0 after the bus is idle again.
- R8: After `tx_start`, `tx_ch` stays stable and no pass runs (`scan_busy`=0) until `tx_done` is 1.
- R9: If `bus_idle` is 1 in the clock where `tx_done` is 1, a new pass starts in the next clock.
- R10: A channel enabled after its visit in the current pass is picked up in the next pass. Its latency from enable to `tx_start` is at most two maximum pass times.
- R11: `NUM_CH` is a parameter that supports 16 and 32 channels, and `ID_W` sets the identifier width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_dir_tx | input | NUM_CH | Per-channel direction, 1 = transmit |
| ch_id | input | NUM_CH*ID_W | Channel identifiers, channel i at bits [i*ID_W +: ID_W] |
| bus_idle | input | 1 | 1 while the CAN bus is idle |
| tx_done | input | 1 | Transmitter acknowledge that the requested frame is finished |
| tx_start | output | 1 | One-clock request to start sending the winning frame |
| tx_ch | output | $clog2(NUM_CH) | Index of the winning channel |
| scan_busy | output | 1 | 1 while a pass is in progress |

## Verification
A wrong visit counter or a wrong per-channel stage sequence changes the pass length. That shows up as a count of `scan_busy` cycles before `tx_start`, which must match 2*NUM_CH + k + 1, and the error is visible at the end of the first pass. A stale or wrongly updated best candidate shows up as a wrong `tx_ch` at the same moment. The cases that expose it are ties, receive channels with small identifiers, and a restart after an abandoned pass with a changed configuration. A hold or abandon state that does not work shows within one clock, as `scan_busy` rising while a request is pending, or `scan_busy` staying high after the bus goes busy.

// File: rtl/can_scan_pkg.sv
package can_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_TEST  = 3'd2,
    ST_CMP   = 3'd3,
    ST_CLOSE = 3'd4,
    ST_HOLD  = 3'd5
  } scan_state_e;
endpackage

// File: rtl/can_scan_chmux.sv
module can_scan_chmux #(
  parameter int NUM_CH = 16,
  parameter int ID_W   = 11,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]      en,
  input  logic [NUM_CH-1:0]      dir_tx,
  input  logic [NUM_CH*ID_W-1:0] ids,
  input  logic [CH_W-1:0]        sel,
  output logic                   is_tx,
  output logic [ID_W-1:0]        id
);
  logic [ID_W-1:0] id_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_split
    assign id_arr[g] = ids[g*ID_W +: ID_W];
  end

  always_comb begin
    is_tx = en[sel] & dir_tx[sel];
    id    = id_arr[sel];
  end
endmodule

// File: rtl/can_scan_best.sv
module can_scan_best #(
  parameter int ID_W  = 11,
  parameter int CH_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            upd,
  input  logic [ID_W-1:0] cand_id,
  input  logic [CH_W-1:0] cand_ch,
  output logic            found,
  output logic [CH_W-1:0] best_ch
);
  logic [ID_W-1:0] best_id;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found   <= 1'b0;
      best_id <= '0;
      best_ch <= '0;
    end else if (upd && (!found || cand_id < best_id)) begin
      found   <= 1'b1;
      best_id <= cand_id;
      best_ch <= cand_ch;
    end
  end
endmodule

// File: rtl/can_tx_scan_arb.sv
module can_tx_scan_arb
  import can_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ID_W   = 11,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      ch_en,
  input  logic [NUM_CH-1:0]      ch_dir_tx,
  input  logic [NUM_CH*ID_W-1:0] ch_id,
  input  logic                   bus_idle,
  input  logic                   tx_done,
  output logic                   tx_start,
  output logic [CH_W-1:0]        tx_ch,
  output logic                   scan_busy
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  scan_state_e     state, state_n;
  logic [CH_W-1:0] ch_idx, ch_idx_n;
  logic            cur_tx;
  logic [ID_W-1:0] cur_id;
  logic            mux_tx;
  logic [ID_W-1:0] mux_id;
  logic            best_clr, best_upd, found;
  logic [CH_W-1:0] best_ch;
  logic            start_n;

  can_scan_chmux #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_mux (
    .en(ch_en), .dir_tx(ch_dir_tx), .ids(ch_id), .sel(ch_idx),
    .is_tx(mux_tx), .id(mux_id)
  );

  can_scan_best #(.ID_W(ID_W), .CH_W(CH_W)) u_best (
    .clk(clk), .rst(rst), .clear(best_clr), .upd(best_upd),
    .cand_id(cur_id), .cand_ch(ch_idx), .found(found), .best_ch(best_ch)
  );

  // Next-state logic: visit = LOAD, TEST (+ CMP for transmit channels)
  always_comb begin
    state_n  = state;
    ch_idx_n = ch_idx;
    best_clr = 1'b0;
    best_upd = 1'b0;
    start_n  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        best_clr = 1'b1;
        if (bus_idle) begin
          state_n  = ST_LOAD;
          ch_idx_n = '0;
        end
      end
      ST_LOAD: begin
        if (!bus_idle) begin
          state_n  = ST_IDLE;
          best_clr = 1'b1;
        end else begin
          state_n  = ST_TEST;
        end
      end
      ST_TEST, ST_CMP: begin
        if (!bus_idle) begin
          state_n  = ST_IDLE;
          best_clr = 1'b1;
        end else if (state == ST_TEST && cur_tx) begin
          state_n  = ST_CMP;
        end else begin
          best_upd = (state == ST_CMP);
          if (ch_idx == LAST_CH) begin
            state_n = ST_CLOSE;
          end else begin
            state_n  = ST_LOAD;
            ch_idx_n = ch_idx + 1'b1;
          end
        end
      end
      ST_CLOSE: begin
        if (!bus_idle) begin
          state_n  = ST_IDLE;
          best_clr = 1'b1;
        end else if (found) begin
          state_n = ST_HOLD;
          start_n = 1'b1;
        end else begin
          state_n  = ST_LOAD;
          ch_idx_n = '0;
          best_clr = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tx_done) begin
          best_clr = 1'b1;
          ch_idx_n = '0;
          state_n  = bus_idle ? ST_LOAD : ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ch_idx    <= '0;
      cur_tx    <= 1'b0;
      cur_id    <= '0;
      tx_start  <= 1'b0;
      tx_ch     <= '0;
      scan_busy <= 1'b0;
    end else begin
      state     <= state_n;
      ch_idx    <= ch_idx_n;
      tx_start  <= start_n;
      scan_busy <= (state_n == ST_LOAD) || (state_n == ST_TEST) ||
                   (state_n == ST_CMP)  || (state_n == ST_CLOSE);
      if (state == ST_LOAD) begin
        cur_tx <= mux_tx;
        cur_id <= mux_id;
      end
      if (start_n) tx_ch <= best_ch;
    end
  end
endmodule

// File: rtl/can_tx_scan_arb_chk.sv
module can_tx_scan_arb_chk #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_idle,
  input logic            tx_done,
  input logic            tx_start,
  input logic [CH_W-1:0] tx_ch,
  input logic            scan_busy
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (tx_start || pend_q) && !tx_done;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);  // R5
  AST_HOLD_CH: assert property (@(posedge clk) disable iff (rst)
    ((tx_start || pend_q) && !tx_done) |=> $stable(tx_ch));  // R8
  AST_NO_SCAN_PENDING: assert property (@(posedge clk) disable iff (rst)
    (tx_start || pend_q) |-> !scan_busy);  // R8
  AST_ABANDON: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |=> !scan_busy);  // R7
  AST_START_AFTER_PASS: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> ($past(bus_idle) && $past(scan_busy)));  // R1
endmodule

bind can_tx_scan_arb can_tx_scan_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .bus_idle(bus_idle), .tx_done(tx_done),
  .tx_start(tx_start), .tx_ch(tx_ch), .scan_busy(scan_busy)
);

// File: tb/can_tx_scan_arb_tb.sv
module can_tx_scan_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = 11;
  localparam int CW = $clog2(N);
  localparam int PASS_MAX = 3*N + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    ch_en = '0;
  logic [N-1:0]    ch_dir_tx = '0;
  logic [N*IW-1:0] ch_id = '0;
  logic bus_idle = 1'b0;
  logic tx_done = 1'b0;
  logic tx_start, scan_busy;
  logic [CW-1:0] tx_ch;

  int checks = 0;
  int fails = 0;

  can_tx_scan_arb #(.NUM_CH(N), .ID_W(IW)) u_dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_dir_tx(ch_dir_tx), .ch_id(ch_id),
    .bus_idle(bus_idle), .tx_done(tx_done), .tx_start(tx_start),
    .tx_ch(tx_ch), .scan_busy(scan_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_pass(output int win, output int len);
    int best;
    int k;
    win = -1; k = 0; best = 0;
    for (int i = 0; i < N; i++) begin
      if (ch_en[i] && ch_dir_tx[i]) begin
        k++;
        if (win < 0 || int'(ch_id[i*IW +: IW]) < best) begin
          win = i;
          best = int'(ch_id[i*IW +: IW]);
        end
      end
    end
    len = 2*N + k + 1;
  endfunction

  task automatic set_id(input int ch, input int v);
    ch_id[ch*IW +: IW] = IW'(v);
  endtask

  // Raise bus_idle from the idle state, count busy cycles until tx_start
  task automatic measure(output int cnt, output int ch, output bit got);
    got = 0; cnt = 0; ch = -1;
    @(negedge clk); bus_idle = 1'b1;
    for (int c = 0; c < 4*PASS_MAX && !got; c++) begin
      @(negedge clk);
      if (tx_start) begin
        got = 1'b1;
        ch = int'(tx_ch);
      end else if (scan_busy) cnt++;
    end
  endtask

  // Hold the request, then acknowledge with the bus going busy
  task automatic release_req(input int hold, input string tag);
    int held;
    held = int'(tx_ch);
    chk(!scan_busy, tag, int'(scan_busy), 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(!tx_start, "R5 pulse width", int'(tx_start), 0);
      chk(int'(tx_ch) == held && !scan_busy, "R8 hold", int'(tx_ch), held);
    end
    tx_done = 1'b1; bus_idle = 1'b0;
    @(negedge clk); tx_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_case(input string tag);
    int win, len, cnt, ch;
    bit got;
    ref_pass(win, len);
    measure(cnt, ch, got);
    chk(got, {tag, " start seen"}, int'(got), 1);
    chk(cnt == len, {tag, " R2 pass length"}, cnt, len);
    chk(ch == win, {tag, " R3 winner"}, ch, win);
    release_req(2, {tag, " R8 busy low"});
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int win, len, cnt, ch, lat;
    bit got;
    repeat (3) @(negedge clk);
    chk(!tx_start && !scan_busy, "R5 reset outputs", int'(tx_start), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!scan_busy, "R1 no scan while bus busy", int'(scan_busy), 0);

    // R1 R2 R11: lone transmit channel at every index
    for (int i = 0; i < N; i++) begin
      ch_en = '0; ch_dir_tx = '0;
      ch_en[i] = 1'b1; ch_dir_tx[i] = 1'b1; set_id(i, 7);
      run_case("R1 lone channel");
    end

    // R2: every channel transmits, longest pass 3N+1
    ch_en = '1; ch_dir_tx = '1;
    for (int i = 0; i < N; i++) set_id(i, 2000 - i);
    ref_pass(win, len);
    chk(len == PASS_MAX, "R2 max pass model", len, PASS_MAX);
    run_case("R2 all transmit");

    // R3: receive and disabled channels ignored despite small ids
    ch_en = '0; ch_dir_tx = '0;
    ch_en[3] = 1'b1; set_id(3, 0);
    ch_en[9] = 1'b1; ch_dir_tx[9] = 1'b1; set_id(9, 100);
    ch_dir_tx[12] = 1'b1; set_id(12, 50);
    ch_en[14] = 1'b1; ch_dir_tx[14] = 1'b1; set_id(14, 300);
    measure(cnt, ch, got);
    chk(ch == 9, "R3 ignore rx/disabled", ch, 9);
    release_req(1, "R8 busy low");

    // R4: equal identifiers
    ch_en = '0; ch_dir_tx = '0;
    ch_en[2] = 1'b1; ch_dir_tx[2] = 1'b1; set_id(2, 5);
    ch_en[7] = 1'b1; ch_dir_tx[7] = 1'b1; set_id(7, 5);
    ch_en[11] = 1'b1; ch_dir_tx[11] = 1'b1; set_id(11, 5);
    measure(cnt, ch, got);
    chk(ch == 2, "R4 tie lower index", ch, 2);
    release_req(1, "R8 busy low");

    // R6: no transmit channel, passes repeat back to back
    ch_en = '1; ch_dir_tx = '0;
    @(negedge clk); bus_idle = 1'b1;
    @(negedge clk);
    got = 1'b0;
    for (int c = 0; c < 3*(2*N+1); c++) begin
      if (!scan_busy || tx_start) got = 1'b1;
      @(negedge clk);
    end
    chk(!got, "R6 continuous empty passes", int'(got), 0);
    bus_idle = 1'b0;
    @(negedge clk);
    chk(!scan_busy, "R7 stop on busy bus", int'(scan_busy), 0);

    // R7: abandon after a candidate was found, restart from channel 0
    ch_en = '0; ch_dir_tx = '0;
    ch_en[0] = 1'b1; ch_dir_tx[0] = 1'b1; set_id(0, 1);
    ch_en[10] = 1'b1; ch_dir_tx[10] = 1'b1; set_id(10, 200);
    @(negedge clk); bus_idle = 1'b1;
    repeat (8) @(negedge clk);
    bus_idle = 1'b0;
    @(negedge clk);
    chk(!scan_busy, "R7 busy low after abandon", int'(scan_busy), 0);
    got = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (tx_start) got = 1'b1;
    end
    chk(!got, "R7 no start after abandon", int'(got), 0);
    ch_en[0] = 1'b0;
    run_case("R7 restart");

    // R9: acknowledge with bus still idle starts next pass at once
    ch_en = '0; ch_dir_tx = '0;
    ch_en[4] = 1'b1; ch_dir_tx[4] = 1'b1;
    measure(cnt, ch, got);
    chk(ch == 4, "R9 setup winner", ch, 4);
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk(scan_busy, "R9 immediate new pass", int'(scan_busy), 1);
    bus_idle = 1'b0;
    @(negedge clk);
    chk(!scan_busy, "R7 abandon second pass", int'(scan_busy), 0);
    @(negedge clk);

    // R10: channel enabled after its visit is taken in the next pass
    ch_en = '0; ch_dir_tx = '0;
    ch_dir_tx[5] = 1'b1; set_id(5, 9);
    @(negedge clk); bus_idle = 1'b1;
    repeat (20) @(negedge clk);
    ch_en[5] = 1'b1;
    lat = 0; got = 1'b0;
    for (int c = 0; c < 4*PASS_MAX && !got; c++) begin
      @(negedge clk);
      lat++;
      if (tx_start) got = 1'b1;
    end
    chk(lat == 48, "R10 next-pass latency", lat, 48);
    chk(lat <= 2*PASS_MAX, "R10 latency bound", lat, 2*PASS_MAX);
    chk(int'(tx_ch) == 5, "R10 late channel wins", int'(tx_ch), 5);
    release_req(1, "R8 busy low");

    // R2 R3 R4: random enables, directions and identifiers
    for (int it = 0; it < 60; it++) begin
      ch_en = N'($urandom); ch_dir_tx = N'($urandom);
      for (int i = 0; i < N; i++)
        set_id(i, (it % 2 == 1) ? int'($urandom % 4) : int'($urandom % 2048));
      ref_pass(win, len);
      if (win < 0) begin
        ch_en[it % N] = 1'b1; ch_dir_tx[it % N] = 1'b1;
      end
      run_case("R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule